// File: doc/BRIEF.md
# Four-Line Receive Character Silo

This block merges the character streams of four serial line receivers into one shared first-in first-out silo and hands them to software through a single 16-bit receive word. The bit-level receivers sit outside. Each one delivers a character as a one-cycle strobe on its own line input, together with framing and parity error flags. Every stored entry is tagged with the number of the line it came from. It also carries its own overrun, framing and parity flags, so software can sort the characters and judge them after they have been merged into one stream.

Software talks to the block through a two-word register port. Word 0 is a control/status register. It holds a self-clearing soft-reset bit, a master scan enable, receive and transmit interrupt enables and a receiver-done flag. Word 1 is the receive word, and each read of it removes the oldest entry. The line inputs have no ready signal. A character is either stored in the cycle its strobe is seen or dropped, and a drop is reported through the overrun flag of the next entry stored. A level interrupt requests service while the silo holds data and receive interrupts are permitted.

Top module: `rx_silo`

## Requirements
- R1: A read of word 1 returns bit 15 = 1 (entry valid), bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 9:8 = line number and bits 7:0 = the character; bits 11:10 read 0.
- R2: Characters leave the silo in arrival order; strobes seen in the same cycle are stored with the lower line number first.
- R3: Line strobes are ignored while the scan enable (word 0 bit 1) is 0 and while a soft reset is in progress.
- R4: Each read of word 1 removes the head entry; a read of word 1 while the silo is empty returns 16'h0000 and changes nothing.
- R5: A character that finds no free slot is dropped, and the next character stored afterwards has its overrun bit set; only that one entry carries it.
- R6: Word 0 reads back bit 0 = clear in progress, bit 1 = scan enable, bit 2 = receive interrupt enable, bit 3 = transmit interrupt enable, bit 7 = receiver done; receiver done is 1 exactly while the silo holds an entry, and all other bits read 0.
- R7: Writing word 0 with bit 0 = 1 empties the silo, drops a pending overrun, zeroes the three enables and ignores the other written bits; bit 0 reads 1 for CLR_CYCLES cycles and then returns to 0.
- R8: irq_rx is 1 exactly when receive interrupt enable, scan enable and receiver done are all 1.
- R9: Read data is registered: reg_rdata shows the result of a read in the cycle after reg_rd is sampled high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_vld | input | 4 | One-cycle character strobe, one per line |
| line_char | input | 32 | Characters, line i on bits 8i+7:8i |
| line_ferr | input | 4 | Framing error flag per line |
| line_perr | input | 4 | Parity error flag per line |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = control/status, 1 = receive word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_rx | output | 1 | Receive interrupt request (level) |

## Verification
A strobe sampled on a clock edge is stored on that same edge, so receiver done and irq_rx change right after that edge. The bench drives on the falling edge and looks at both outputs on the next falling edge. A read is sampled on one edge, and its data is valid after that edge. Because of this, the bench reads reg_rdata one falling edge after it raises reg_rd. A soft reset stays visible for CLR_CYCLES cycles after the write edge. The bench therefore reads bit 0 once straight away, expecting 1. It reads it again after CLR_CYCLES plus two idle cycles, expecting 0.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int NLINES = 4;
  localparam int LINE_W = 2;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              pe;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } silo_ent_t;

  localparam int BIT_CLR  = 0;
  localparam int BIT_SCAN = 1;
  localparam int BIT_RXIE = 2;
  localparam int BIT_TXIE = 3;
  localparam int BIT_DONE = 7;
endpackage

// File: rtl/rx_silo_merge.sv
module rx_silo_merge
  import rx_silo_pkg::*;
#(
  parameter int AW = 6,
  localparam int CW = $clog2(NLINES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     flush,
  input  logic [NLINES-1:0]        vld,
  input  logic [NLINES*CHAR_W-1:0] chars,
  input  logic [NLINES-1:0]        ferr,
  input  logic [NLINES-1:0]        perr,
  input  logic [AW:0]              free,
  output silo_ent_t                ents [NLINES],
  output logic [CW-1:0]            wr_cnt
);
  logic          pend_q;
  logic          pend_d;
  logic [AW:0]   slots;

  always_comb begin
    slots  = free;
    pend_d = pend_q;
    wr_cnt = '0;
    for (int k = 0; k < NLINES; k++) ents[k] = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (accept && vld[i]) begin
        if (slots != '0) begin
          ents[wr_cnt].ovr  = pend_d;
          ents[wr_cnt].fe   = ferr[i];
          ents[wr_cnt].pe   = perr[i];
          ents[wr_cnt].line = LINE_W'(i);
          ents[wr_cnt].ch   = chars[i*CHAR_W +: CHAR_W];
          pend_d = 1'b0;
          wr_cnt = wr_cnt + 1'b1;
          slots  = slots - 1'b1;
        end else begin
          pend_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (flush) pend_q <= 1'b0;
    else            pend_q <= pend_d;
  end

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AW+1)'(wr_cnt) <= free);
endmodule

// File: rtl/rx_silo_store.sv
module rx_silo_store
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(NLINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  silo_ent_t     ents [NLINES],
  input  logic [CW-1:0] wr_cnt,
  input  logic          pop,
  output silo_ent_t     head,
  output logic [AW:0]   count,
  output logic [AW:0]   free
);
  silo_ent_t      mem [DEPTH];
  logic [AW-1:0]  wp, rp;

  assign head = mem[rp];
  assign free = (AW+1)'(DEPTH) - count;

  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int k = 0; k < NLINES; k++) begin
        if (CW'(k) < wr_cnt) mem[AW'(wp + AW'(k))] <= ents[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= AW'(wp + AW'(wr_cnt));
      rp    <= rp + AW'(pop);
      count <= count + (AW+1)'(wr_cnt) - (AW+1)'(pop);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/rx_silo_ctrl.sv
module rx_silo_ctrl
  import rx_silo_pkg::*;
#(
  parameter int CLR_CYCLES = 4,
  localparam int TW = $clog2(CLR_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic [15:0] wdata,
  output logic        scan_en,
  output logic        rx_ie,
  output logic        tx_ie,
  output logic        busy
);
  logic [TW-1:0] clr_t;

  assign busy = (clr_t != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_t   <= '0;
      scan_en <= 1'b0;
      rx_ie   <= 1'b0;
      tx_ie   <= 1'b0;
    end else if (busy) begin
      clr_t <= clr_t - 1'b1;
    end else if (csr_wr) begin
      if (wdata[BIT_CLR]) begin
        clr_t   <= TW'(CLR_CYCLES);
        scan_en <= 1'b0;
        rx_ie   <= 1'b0;
        tx_ie   <= 1'b0;
      end else begin
        scan_en <= wdata[BIT_SCAN];
        rx_ie   <= wdata[BIT_RXIE];
        tx_ie   <= wdata[BIT_TXIE];
      end
    end
  end

  // R7
  clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !busy && wdata[BIT_CLR]) |=> (busy && !scan_en && !rx_ie));
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int CLR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  line_vld,
  input  logic [31:0] line_char,
  input  logic [3:0]  line_ferr,
  input  logic [3:0]  line_perr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq_rx
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(NLINES + 1);

  logic          scan_en, rx_ie, tx_ie, busy;
  logic          rx_done, pop, rd_buf, rd_csr;
  silo_ent_t     ents [NLINES];
  silo_ent_t     head;
  logic [CW-1:0] wr_cnt;
  logic [AW:0]   count, free;

  rx_silo_ctrl #(.CLR_CYCLES(CLR_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(reg_wr && !reg_addr), .wdata(reg_wdata),
    .scan_en(scan_en), .rx_ie(rx_ie), .tx_ie(tx_ie), .busy(busy)
  );

  rx_silo_merge #(.AW(AW)) merge_i (
    .clk(clk), .rst_n(rst_n), .accept(scan_en && !busy), .flush(busy),
    .vld(line_vld), .chars(line_char), .ferr(line_ferr), .perr(line_perr),
    .free(free), .ents(ents), .wr_cnt(wr_cnt)
  );

  rx_silo_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(busy),
    .ents(ents), .wr_cnt(wr_cnt), .pop(pop),
    .head(head), .count(count), .free(free)
  );

  assign rx_done = (count != '0);
  assign rd_buf  = reg_rd && reg_addr;
  assign rd_csr  = reg_rd && !reg_addr;
  assign pop     = rd_buf && rx_done && !busy;
  assign irq_rx  = rx_ie && scan_en && rx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (rd_buf) begin
      reg_rdata <= pop ? {1'b1, head.ovr, head.fe, head.pe, 2'b00, head.line, head.ch}
                       : 16'h0000;
    end else if (rd_csr) begin
      reg_rdata <= '0;
      reg_rdata[BIT_CLR]  <= busy;
      reg_rdata[BIT_SCAN] <= scan_en;
      reg_rdata[BIT_RXIE] <= rx_ie;
      reg_rdata[BIT_TXIE] <= tx_ie;
      reg_rdata[BIT_DONE] <= rx_done;
    end
  end

  // R3
  scan_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !busy && !pop) |=> (count == $past(count)));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && count == '0) |=> (reg_rdata == 16'h0000));
endmodule

// File: tb/rx_silo_tb_top.sv
module rx_silo_tb_top;
  localparam int DEPTH = 8;
  localparam int CLRC  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  line_vld = '0;
  logic [31:0] line_char = '0;
  logic [3:0]  line_ferr = '0, line_perr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_rx;

  int checks = 0;
  int fails  = 0;
  logic [12:0] mq[$];
  logic        mpend = 1'b0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  rx_silo #(.DEPTH(DEPTH), .CLR_CYCLES(CLRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .line_char(line_char),
    .line_ferr(line_ferr), .line_perr(line_perr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_rx(irq_rx)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // Model and drive one strobe cycle (R2 priority, R5 drop rule).
  task automatic push(input logic [3:0] m, input logic [31:0] c,
                      input logic [3:0] fe, input logic [3:0] pe, input bit model_on);
    @(negedge clk);
    line_vld = m; line_char = c; line_ferr = fe; line_perr = pe;
    if (model_on) begin
      for (int i = 0; i < 4; i++) begin
        if (m[i]) begin
          if (mq.size() < DEPTH) begin
            mq.push_back({mpend, fe[i], pe[i], 2'(i), c[i*8 +: 8]});
            mpend = 1'b0;
          end else mpend = 1'b1;
        end
      end
    end
    @(negedge clk); line_vld = '0;
  endtask

  task automatic drain(input string req);
    logic [12:0] e;
    while (mq.size() > 0) begin
      e = mq.pop_front();
      rd_reg(1'b1, rv);
      check(req, rv, {1'b1, e[12:10], 2'b00, e[9:8], e[7:0]});
    end
    rd_reg(1'b1, rv);
    check("R4 empty read", rv, 16'h0000);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8 reset irq", {15'b0, irq_rx}, 16'h0000);
    rd_reg(1'b0, rv);
    check("R6 reset csr", rv, 16'h0000);
    rd_reg(1'b1, rv);
    check("R4 reset empty", rv, 16'h0000);

    // R3: scan disabled, strobes ignored
    push(4'hF, 32'h11223344, 4'h0, 4'h0, 1'b0);
    rd_reg(1'b0, rv);
    check("R3 scan off done", rv, 16'h0000);

    wr_csr(16'h0006);  // scan + rx ie
    rd_reg(1'b0, rv);
    check("R6 enables", rv, 16'h0006);

    // R1/R2: sweep all strobe masks and flag patterns
    for (int m = 1; m < 16; m++) begin
      push(4'(m), {8'(m*16+3), 8'(m*16+2), 8'(m*16+1), 8'(m*16)},
           4'(m ^ 5), 4'(~m), 1'b1);
      check("R8 irq set", {15'b0, irq_rx}, 16'h0001);
      rd_reg(1'b0, rv);
      check("R6 done set", rv, 16'h0086);
      drain("R1 R2 word");
      check("R8 irq clear", {15'b0, irq_rx}, 16'h0000);
    end

    // R2: order across cycles
    push(4'b1000, 32'hAA000000, 4'h0, 4'h0, 1'b1);
    push(4'b0101, 32'h00BB00CC, 4'h1, 4'h4, 1'b1);
    push(4'b0010, 32'h0000DD00, 4'h0, 4'h2, 1'b1);
    drain("R2 order");

    // R5: overflow
    push(4'hF, 32'h03020100, 4'h0, 4'h0, 1'b1);
    push(4'hF, 32'h07060504, 4'h0, 4'h0, 1'b1);
    push(4'h7, 32'h000A0908, 4'h0, 4'h0, 1'b1);
    rd_reg(1'b1, rv);
    check("R4 pop head", rv, {1'b1, mq[0][12:10], 2'b00, mq[0][9:8], mq[0][7:0]});
    void'(mq.pop_front());
    push(4'b0110, 32'h00F1F000, 4'h0, 4'h0, 1'b1);
    check("R5 overrun once", {15'b0, mq[DEPTH-1][12]}, 16'h0001);
    drain("R5 drain");

    // R8: interrupt off with rx ie clear
    wr_csr(16'h0002);
    push(4'h1, 32'h5A, 4'h0, 4'h0, 1'b1);
    check("R8 irq gated", {15'b0, irq_rx}, 16'h0000);
    wr_csr(16'h000E);
    check("R8 irq enabled", {15'b0, irq_rx}, 16'h0001);

    // R7: soft reset
    push(4'h3, 32'h6B6A, 4'h0, 4'h0, 1'b1);
    wr_csr(16'h00FF);
    mq.delete(); mpend = 1'b0;
    rd_reg(1'b0, rv);
    check("R7 clear bit busy", rv & 16'h0001, 16'h0001);
    push(4'hF, 32'h01010101, 4'h0, 4'h0, 1'b0);  // R3: ignored during clear
    repeat (CLRC + 2) @(negedge clk);
    rd_reg(1'b0, rv);
    check("R7 clear done", rv, 16'h0000);
    check("R7 irq low", {15'b0, irq_rx}, 16'h0000);
    rd_reg(1'b1, rv);
    check("R7 silo empty", rv, 16'h0000);

    // R9: read data holds between reads
    wr_csr(16'h0002);
    push(4'h4, 32'h00770000, 4'h0, 4'h0, 1'b1);
    rd_reg(1'b1, rv);
    repeat (3) @(negedge clk);
    check("R9 hold", reg_rdata, 16'h8277);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule